// File: doc/BRIEF.md
# Selectable-Policy Set Replacement Unit

This block sits on the tag side of a set-associative cache and names the way to be replaced in the set being looked up. The tag compare and the data arrays live elsewhere; the unit receives the set index, the valid bits of that set's ways and a policy code. It returns a victim way and a flag that says whether that way is empty. Replacement order is kept per set as a recency rank for each way. The unit offers three policies, chosen at run time through one select input: evict the way touched least recently, evict the way touched most recently, or evict a pseudo-random way.

Each access strobe reports a hit, with the way that hit, or a miss. On a miss, the way being filled is the victim that the unit presents in that same cycle. In both cases the touched way becomes the newest way of its set. The victim output is combinational on the current recency state, so a lookup and an update can share one cycle. A geometry with a single way has nothing to choose, and the policy input then has no effect.

No state machine is needed. The only sequential state is the recency rank table and a 16-bit LFSR, and neither walks through a sequence of control steps. The policy is a decoded enumeration with four codes.

Top module: `repl_unit`

## Requirements
- R1: After reset, every set orders its ways from way 0 (oldest) up to way WAYS-1 (newest), and the LFSR holds 16'hACE1.
- R2: If any bit of `valid_vec` is 0, the victim is the lowest-indexed way whose bit is 0 and `victim_invalid` is 1. If all bits are 1, `victim_invalid` is 0.
- R3: With every way valid and `policy_sel` equal to 2'b00 or 2'b11, the victim is the way whose last touch is oldest.
- R4: With every way valid and `policy_sel` equal to 2'b01, the victim is the way touched most recently.
- R5: With every way valid and `policy_sel` equal to 2'b10, the victim is the low log2(WAYS) bits of the LFSR. The LFSR shifts toward its MSB, and bit 0 receives bit15 ^ bit13 ^ bit12 ^ bit10. It advances once on each clock edge with `acc_valid` high and holds its value otherwise.
- R6: On an edge with `acc_valid` high, the touched way becomes the newest way of `acc_set`, and the other ways of that set keep their relative order. The touched way is `acc_way` when `acc_hit` is 1, and otherwise it is the victim presented in that cycle. The new order shows on the victim output from the next cycle.
- R7: An access to one set leaves the order of every other set unchanged.
- R8: With WAYS = 1, the victim is always way 0 whatever `policy_sel` is, and `victim_invalid` is the inverse of `valid_vec[0]`.
- R9: With two ways, where a miss fills the victim way, the stream A,B,C,A,B,C,A,B,C gives 9 misses under R3 and 6 under R4. The stream A,A,B,B,C,C,A,B,C gives 6 misses under R3 and 4 under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe: update recency for `acc_set` |
| acc_hit | input | 1 | 1 = hit on `acc_way`; 0 = miss that fills the victim |
| acc_way | input | WAYW | Way that hit |
| acc_set | input | SETW | Set being looked up and updated |
| valid_vec | input | WAYS | Valid bit of each way of `acc_set` |
| policy_sel | input | 2 | 00/11 least recent, 01 most recent, 10 pseudo-random |
| victim_way | output | WAYW | Way chosen for replacement |
| victim_invalid | output | 1 | The chosen way is empty |

## Verification
Two things can happen in one cycle: a miss fill that commits the way the unit is presenting, and the lookup that produces that victim. The bench provokes this with strobed misses on sets whose ways are all valid. It checks that the victim shown in the miss cycle follows the old order and that the victim on the next cycle follows the new one. Random traffic across sets and policies hits the same overlap many times. A timestamp model in the bench predicts every victim, and a bench copy of the LFSR, built from the stated taps, predicts the random choices.

// File: rtl/repl_pkg.sv
package repl_pkg;
    typedef enum logic [1:0] {
        POL_OLDEST  = 2'b00,
        POL_NEWEST  = 2'b01,
        POL_RANDOM  = 2'b10,
        POL_OLDEST2 = 2'b11
    } repl_policy_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/repl_rank_store.sv
module repl_rank_store #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    parameter int SETW = 3,
    parameter int AW   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_en,
    input  logic [SETW-1:0]              upd_set,
    input  logic [AW-1:0]                upd_way,
    input  logic [SETW-1:0]              rd_set,
    output logic [WAYS-1:0][AW-1:0]      rd_rank
);
    // rank 0 = newest, rank WAYS-1 = oldest
    logic [WAYS-1:0][AW-1:0] rank_q [SETS];
    logic [WAYS-1:0][AW-1:0] upd_row;
    logic [WAYS-1:0][AW-1:0] next_row;

    assign upd_row = rank_q[upd_set];
    assign rd_rank = rank_q[rd_set];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (AW'(w) == upd_way)
                next_row[w] = '0;
            else if (upd_row[w] < upd_row[upd_way])
                next_row[w] = upd_row[w] + AW'(1);
            else
                next_row[w] = upd_row[w];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= AW'(WAYS - 1 - w);
        end else if (upd_en) begin
            rank_q[upd_set] <= next_row;
        end
    end

    // the touched way must read back as newest on the following cycle
    assert_touch_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> rank_q[$past(upd_set)][$past(upd_way)] == '0);
endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
    parameter int          OUTW = 2,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [OUTW-1:0] rnd
);
    logic [15:0] lfsr_q;
    logic        fb;

    assign fb  = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
    assign rnd = lfsr_q[OUTW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else if (adv)
            lfsr_q <= {lfsr_q[14:0], fb};
    end

    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000);
    assert_lfsr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(lfsr_q));
endmodule

// File: rtl/repl_pick.sv
module repl_pick
    import repl_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int AW   = 2
) (
    input  logic [WAYS-1:0]         valid_vec,
    input  logic [WAYS-1:0][AW-1:0] rank,
    input  repl_policy_e            policy,
    input  logic [AW-1:0]           rnd,
    output logic [AW-1:0]           victim_way,
    output logic                    victim_invalid
);
    logic          empty_found;
    logic [AW-1:0] empty_way;
    logic [AW-1:0] oldest_way;
    logic [AW-1:0] newest_way;
    logic [AW-1:0] policy_way;

    always_comb begin
        empty_found = 1'b0;
        empty_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                empty_found = 1'b1;
                empty_way   = AW'(w);
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        newest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank[w] == AW'(WAYS - 1)) oldest_way = AW'(w);
            if (rank[w] == '0)            newest_way = AW'(w);
        end
    end

    always_comb begin
        unique case (policy)
            POL_NEWEST:               policy_way = newest_way;
            POL_RANDOM:               policy_way = rnd;
            POL_OLDEST, POL_OLDEST2:  policy_way = oldest_way;
            default:                  policy_way = oldest_way;
        endcase
    end

    assign victim_way     = empty_found ? empty_way : policy_way;
    assign victim_invalid = empty_found;
endmodule

// File: rtl/repl_unit.sv
module repl_unit
    import repl_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_hit,
    input  logic [WAYW-1:0] acc_way,
    input  logic [SETW-1:0] acc_set,
    input  logic [WAYS-1:0] valid_vec,
    input  logic [1:0]      policy_sel,
    output logic [WAYW-1:0] victim_way,
    output logic            victim_invalid
);
    generate
        if (WAYS == 1) begin : g_direct
            assign victim_way     = '0;
            assign victim_invalid = ~valid_vec[0];
        end else begin : g_assoc
            logic [WAYS-1:0][WAYW-1:0] rank;
            logic [WAYW-1:0]           rnd;
            logic [WAYW-1:0]           touch_way;

            assign touch_way = acc_hit ? acc_way : victim_way;

            repl_rank_store #(.SETS(SETS), .WAYS(WAYS), .SETW(SETW), .AW(WAYW)) u_rank (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd_en  (acc_valid),
                .upd_set (acc_set),
                .upd_way (touch_way),
                .rd_set  (acc_set),
                .rd_rank (rank)
            );

            repl_lfsr #(.OUTW(WAYW), .SEED(LFSR_SEED)) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (acc_valid),
                .rnd   (rnd)
            );

            repl_pick #(.WAYS(WAYS), .AW(WAYW)) u_pick (
                .valid_vec      (valid_vec),
                .rank           (rank),
                .policy         (repl_policy_e'(policy_sel)),
                .rnd            (rnd),
                .victim_way     (victim_way),
                .victim_invalid (victim_invalid)
            );

            assert_empty_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
                victim_invalid |-> !valid_vec[victim_way]);
            assert_full_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (&valid_vec) |-> !victim_invalid);
            assert_victim_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                32'(victim_way) < WAYS);
            assert_way0_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_vec[0] |-> (victim_way == '0 && victim_invalid));
        end
    endgenerate
endmodule

// File: tb/sim_repl_unit.sv
module sim_repl_unit;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- main instance: 8 sets, 4 ways ----------------
    logic       rst_n = 1'b0;
    logic       a_valid = 0, a_hit = 0;
    logic [1:0] a_way = 0;
    logic [2:0] a_set = 0;
    logic [3:0] a_vv = 4'hF;
    logic [1:0] a_pol = 0;
    logic [1:0] v_way;
    logic       v_inv;

    repl_unit #(.SETS(8), .WAYS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(a_valid), .acc_hit(a_hit),
        .acc_way(a_way), .acc_set(a_set), .valid_vec(a_vv), .policy_sel(a_pol),
        .victim_way(v_way), .victim_invalid(v_inv));

    // timestamp model: larger stamp = touched later
    int          stamp [8][4];
    int          tnow;
    logic [15:0] mlfsr;
    int          exp_inv;

    task automatic model_reset();
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) stamp[s][w] = w;
        tnow  = 4;
        mlfsr = 16'hACE1;
    endtask

    function automatic int exp_victim(int s, logic [3:0] vv, logic [1:0] pol);
        int best;
        exp_inv = 0;
        for (int w = 0; w < 4; w++)
            if (!vv[w]) begin exp_inv = 1; return w; end
        if (pol == 2'b10) return int'(mlfsr[1:0]);
        best = 0;
        for (int w = 1; w < 4; w++) begin
            if (pol == 2'b01 && stamp[s][w] > stamp[s][best]) best = w;
            if (pol != 2'b01 && stamp[s][w] < stamp[s][best]) best = w;
        end
        return best;
    endfunction

    function automatic string req_of(int inv, logic [1:0] pol);
        if (inv != 0) return "R2";
        if (pol == 2'b01) return "R4";
        if (pol == 2'b10) return "R5";
        return "R3";
    endfunction

    task automatic step(bit acc, bit hit, int way, int s, logic [3:0] vv, logic [1:0] pol, string tag);
        int ev, tw;
        @(negedge clk);
        a_valid = acc; a_hit = hit; a_way = 2'(way); a_set = 3'(s); a_vv = vv; a_pol = pol;
        #1;
        ev = exp_victim(s, vv, pol);
        chk({tag, "/", req_of(exp_inv, pol), " victim"}, int'(v_way), ev);
        chk({tag, "/", req_of(exp_inv, pol), " flag"}, int'(v_inv), exp_inv);
        if (acc) begin
            tw = hit ? way : ev;
            stamp[s][tw] = tnow; tnow++;
            mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
        end
    endtask

    // ---------------- two-way instance for stream counts ----------------
    logic       rst1_n = 1'b0;
    logic       b_valid = 0, b_hit = 0, b_way = 0;
    logic [1:0] b_vv = 0;
    logic [1:0] b_pol = 0;
    logic       bv_way, bv_inv;

    repl_unit #(.SETS(2), .WAYS(2)) u1 (
        .clk(clk), .rst_n(rst1_n), .acc_valid(b_valid), .acc_hit(b_hit),
        .acc_way(b_way), .acc_set(1'b0), .valid_vec(b_vv), .policy_sel(b_pol),
        .victim_way(bv_way), .victim_invalid(bv_inv));

    task automatic run_stream(int seq [9], logic [1:0] pol, int exp_miss, string tag);
        int tg [2];
        bit vl [2];
        int misses, w;
        misses = 0; vl[0] = 0; vl[1] = 0;
        @(negedge clk); rst1_n = 0; b_valid = 0;
        @(negedge clk); rst1_n = 1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            w = -1;
            for (int k = 0; k < 2; k++) if (vl[k] && tg[k] == seq[i]) w = k;
            b_valid = 1; b_pol = pol; b_vv = {vl[1], vl[0]};
            b_hit = (w >= 0); b_way = (w >= 0) ? w[0] : 1'b0;
            #1;
            if (w < 0) begin
                misses++;
                tg[bv_way] = seq[i]; vl[bv_way] = 1;
            end
        end
        @(negedge clk); b_valid = 0;
        chk({"R9 ", tag}, misses, exp_miss);
    endtask

    // ---------------- direct-mapped instance ----------------
    logic       c_valid = 0, c_hit = 0;
    logic [0:0] c_vv = 0;
    logic [1:0] c_pol = 0;
    logic       cv_way, cv_inv;

    repl_unit #(.SETS(2), .WAYS(1)) u2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(c_valid), .acc_hit(c_hit),
        .acc_way(1'b0), .acc_set(1'b0), .valid_vec(c_vv), .policy_sel(c_pol),
        .victim_way(cv_way), .victim_invalid(cv_inv));

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s1 [9] = '{0, 1, 2, 0, 1, 2, 0, 1, 2};
        int s2 [9] = '{0, 0, 1, 1, 2, 2, 0, 1, 2};
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1; rst1_n = 1;

        // R1: reset order and seed
        step(0, 0, 0, 5, 4'hF, 2'b00, "R1 oldest");
        step(0, 0, 0, 5, 4'hF, 2'b01, "R1 newest");
        step(0, 0, 0, 5, 4'hF, 2'b10, "R1 seed");
        // R2: empty ways first, lowest index
        step(0, 0, 0, 1, 4'b0101, 2'b01, "R2 lowest");
        step(0, 0, 0, 1, 4'b0111, 2'b10, "R2 top");
        // R6/R3: hit on way 0 makes way 1 oldest
        step(1, 1, 0, 2, 4'hF, 2'b00, "R6 hit");
        step(0, 0, 0, 2, 4'hF, 2'b11, "R6 after");
        // R7: set 3 untouched
        step(0, 0, 0, 3, 4'hF, 2'b00, "R7 other");
        // R6 same-cycle miss: victim shown now, then next oldest
        step(1, 0, 0, 4, 4'hF, 2'b00, "R6 miss");
        step(0, 0, 0, 4, 4'hF, 2'b00, "R6 next");
        step(0, 0, 0, 4, 4'hF, 2'b01, "R4 filled");
        // R5: LFSR holds without strobes, steps with them
        step(0, 0, 0, 0, 4'hF, 2'b10, "R5 hold");
        step(1, 1, 3, 0, 4'hF, 2'b10, "R5 adv");
        step(0, 0, 0, 0, 4'hF, 2'b10, "R5 next");

        // random traffic with a fixed seed
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] vv;
            vv = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
            step(1'($urandom()), 1'($urandom()), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)), vv, 2'($urandom()), "rand");
        end
        @(negedge clk); a_valid = 0;

        // R8: direct-mapped ignores policy
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            c_pol = 2'(i); c_vv = 1'(i >> 2); c_valid = 1'(i); c_hit = 1'(i >> 1);
            #1;
            chk("R8 victim", int'(cv_way), 0);
            chk("R8 flag", int'(cv_inv), (i >> 2) ? 0 : 1);
        end

        // R9: stream miss counts
        run_stream(s1, 2'b00, 9, "stream1 oldest");
        run_stream(s1, 2'b01, 6, "stream1 newest");
        run_stream(s2, 2'b00, 6, "stream2 oldest");
        run_stream(s2, 2'b01, 4, "stream2 newest");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule